// File: doc/BRIEF.md
# Power-Down Reset Sequencer with Emulated Self-Test

This block holds a set of up to 32 accelerator blocks in reset or releases them, one control word per block. Software writes a single request bit in a block's word to ask for power-down (1) or release (0). Each block then walks through a fixed sequence of phases: running, falling into power-down, held down, running an emulated built-in self-test, and back to running. The same word reports, in two status bits, whether the block has fully reached power-down or is fully active. During a transition both status bits read 0.

The self-test phase is deliberately long. Its length, and the length of the power-down phase, are parameters counted in clock cycles, so that a real chip can set the self-test window to tens of milliseconds. A parameter mask states which block indices exist. An index outside the mask reads as zero, ignores writes and keeps its reset line asserted. Each block drives one active-low reset output. That output is high while the block runs or self-tests, and low while it falls into power-down or is held down.

Top module: `pd_reset_seq`

## Requirements
- R1: The control word of block n is at byte address 4*n. Address bits [1:0] are ignored. Read data appears on `bus_rdata` on the clock edge that follows the read request and holds until the next read.
- R2: Word bit 0 is the power-down request. A write sets it from `bus_wdata[0]`, with 1 meaning power-down and 0 meaning release. A read returns its current value.
- R3: After reset every valid block has its request set and is held down. Its word reads 0x0800_0001 and its `blk_rst_n` bit is 0.
- R4: A running block with its request set enters the falling phase on the next edge. There `blk_rst_n` is 0 and status bits 27 and 29 read 0. After PD_CYCLES edges it reaches the down phase, where bit 27 reads 1.
- R5: A down block with its request clear enters self-test on the next edge. There `blk_rst_n` is 1 and bits 27 and 29 read 0. After SELFTEST_CYCLES edges it becomes active, where bit 29 reads 1 and `blk_rst_n` stays 1.
- R6: Bits 27 (down) and 29 (active) are never 1 together, and both read 0 in the falling and self-test phases.
- R7: A request change during the falling or self-test phase does not shorten or abort that phase. The block completes the phase and then heads toward the newly requested state.
- R8: Writes to bits other than bit 0 have no effect. Bits other than 0, 27 and 29 always read 0.
- R9: An index whose bit in VALID_MASK is 0 reads 0, ignores writes and keeps its `blk_rst_n` bit at 0.
- R10: Each block sequences on its own timing, unaffected by requests to other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, ADDR_W = clog2(NUM_BLK)+2 |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rdata | output | 32 | Registered read data |
| blk_rst_n | output | NUM_BLK | Active-low reset per block |

## Verification
The bench goes after request changes that land in the middle of a phase. A design that aborted the phase would drop or raise a reset line early, and the cycle-by-cycle comparison of every reset line would flag that edge. It checks the exact edge on which a falling or self-test phase ends, where an off-by-one counter shows up as a reset line or status word one cycle away from the reference. Invalid indices and writes that set every bit but the request are aimed at decoders that alias addresses or store stray bits. Two blocks released some cycles apart check that the per-block counters do not leak into each other.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE   = 2'd0,
        PS_FALL     = 2'd1,
        PS_OFF      = 2'd2,
        PS_SELFTEST = 2'd3
    } pd_state_e;

    localparam int REQ_POS    = 0;
    localparam int DOWN_POS   = 27;
    localparam int ACTIVE_POS = 29;

    typedef struct packed {
        logic req;
        logic is_down;
        logic is_active;
    } blk_view_t;

    function automatic logic [31:0] pack_word(blk_view_t v);
        logic [31:0] w;
        w             = '0;
        w[REQ_POS]    = v.req;
        w[DOWN_POS]   = v.is_down;
        w[ACTIVE_POS] = v.is_active;
        return w;
    endfunction

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/pdseq_blk.sv
module pdseq_blk
    import pdseq_pkg::*;
#(
    parameter int unsigned PD_CYCLES       = 8,
    parameter int unsigned SELFTEST_CYCLES = 400
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_stb,
    input  logic      wr_val,
    output blk_view_t view,
    output logic      rst_n
);
    localparam int unsigned CW = cnt_width(PD_CYCLES, SELFTEST_CYCLES);
    localparam logic [CW-1:0] PD_LOAD = CW'(PD_CYCLES - 1);
    localparam logic [CW-1:0] ST_LOAD = CW'(SELFTEST_CYCLES - 1);

    pd_state_e     st;
    logic          req;
    logic [CW-1:0] cnt;
    logic          cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b1;
            st  <= PS_OFF;
            cnt <= '0;
        end else begin
            if (wr_stb) begin
                req <= wr_val;
            end
            unique case (st)
                PS_ACTIVE: begin
                    if (req) begin
                        st  <= PS_FALL;
                        cnt <= PD_LOAD;
                    end
                end
                PS_FALL: begin
                    if (cnt_zero) st <= PS_OFF;
                    else          cnt <= cnt - 1'b1;
                end
                PS_OFF: begin
                    if (!req) begin
                        st  <= PS_SELFTEST;
                        cnt <= ST_LOAD;
                    end
                end
                PS_SELFTEST: begin
                    if (cnt_zero) st <= PS_ACTIVE;
                    else          cnt <= cnt - 1'b1;
                end
                default: st <= PS_OFF;
            endcase
        end
    end

    always_comb begin
        view.req       = req;
        view.is_down   = (st == PS_OFF);
        view.is_active = (st == PS_ACTIVE);
        rst_n          = (st == PS_ACTIVE) || (st == PS_SELFTEST);
    end

    // R4: a running block with its request set starts falling on the next edge
    p_fall_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (st == PS_ACTIVE && req) |=> (st == PS_FALL));

    // R7: an unfinished phase is never cut short by a request change
    p_fall_completes_r7: assert property (@(posedge clk) disable iff (rst)
        (st == PS_FALL && !cnt_zero) |=> (st == PS_FALL));

    p_selftest_completes_r7: assert property (@(posedge clk) disable iff (rst)
        (st == PS_SELFTEST && !cnt_zero) |=> (st == PS_SELFTEST));

    // R5: the active phase is only ever entered from self-test
    p_active_from_selftest_r5: assert property (@(posedge clk) disable iff (rst)
        (st == PS_ACTIVE && $past(st) != PS_ACTIVE) |-> ($past(st) == PS_SELFTEST));

    // R5: a down block with its request set stays down
    p_off_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (st == PS_OFF && req) |=> (st == PS_OFF));

endmodule

// File: rtl/pdseq_regif.sv
module pdseq_regif
    import pdseq_pkg::*;
#(
    parameter int unsigned       NUM_BLK    = 32,
    parameter int unsigned       ADDR_W     = 7,
    parameter logic [NUM_BLK-1:0] VALID_MASK = '1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_valid,
    input  logic                          bus_write,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  blk_view_t [NUM_BLK-1:0]       views,
    output logic [NUM_BLK-1:0]            wr_stb,
    output logic [31:0]                   rdata
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic             rd_req;
    logic [1:0]       unused_addr_lo;

    assign idx            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lo = bus_addr[1:0];
    assign idx_ok         = (32'(idx) < NUM_BLK) && VALID_MASK[idx];
    assign rd_req         = bus_valid && !bus_write;

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_stb
        if (VALID_MASK[i]) begin : g_on
            assign wr_stb[i] = bus_valid && bus_write && (32'(idx) == i);
        end else begin : g_off
            assign wr_stb[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= idx_ok ? pack_word(views[idx]) : 32'h0;
        end
    end

    // R9: an access to a missing index reads back zero
    p_invalid_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !idx_ok) |=> (rdata == 32'h0));

    // R1: read data stays put while no read is requested
    p_rdata_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (!rd_req) |=> $stable(rdata));

    // R6: the down and active bits never show together
    p_status_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(rdata[DOWN_POS] && rdata[ACTIVE_POS]));

    // R1: at most one block is addressed by a write
    p_one_stb_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

endmodule

// File: rtl/pd_reset_seq.sv
module pd_reset_seq
    import pdseq_pkg::*;
#(
    parameter int unsigned        NUM_BLK         = 32,
    parameter logic [NUM_BLK-1:0] VALID_MASK      = 32'h0000_1FFF,
    parameter int unsigned        PD_CYCLES       = 8,
    parameter int unsigned        SELFTEST_CYCLES = 400,
    localparam int unsigned       ADDR_W          = $clog2(NUM_BLK) + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_BLK-1:0] blk_rst_n
);
    blk_view_t [NUM_BLK-1:0] views;
    logic [NUM_BLK-1:0]      wr_stb;
    logic                    unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:1];

    pdseq_regif #(
        .NUM_BLK    (NUM_BLK),
        .ADDR_W     (ADDR_W),
        .VALID_MASK (VALID_MASK)
    ) regif_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .views     (views),
        .wr_stb    (wr_stb),
        .rdata     (bus_rdata)
    );

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
        if (VALID_MASK[i]) begin : g_live
            pdseq_blk #(
                .PD_CYCLES       (PD_CYCLES),
                .SELFTEST_CYCLES (SELFTEST_CYCLES)
            ) blk_i (
                .clk    (clk),
                .rst    (rst),
                .wr_stb (wr_stb[i]),
                .wr_val (bus_wdata[REQ_POS]),
                .view   (views[i]),
                .rst_n  (blk_rst_n[i])
            );
        end else begin : g_dead
            assign views[i]     = '0;
            assign blk_rst_n[i] = 1'b0;
        end
    end

    // R3: reset leaves every reset line asserted on the first cycle out of reset
    p_reset_holds_lines_r3: assert property (@(posedge clk)
        $past(rst) |-> (blk_rst_n == '0));

endmodule

// File: tb/pd_reset_seq_tb_top.sv
module pd_reset_seq_tb_top;
    localparam int NB   = 32;
    localparam int PD   = 8;
    localparam int ST   = 400;
    localparam logic [NB-1:0] VMASK = 32'h0000_1FFF;
    localparam int AW   = $clog2(NB) + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NB-1:0] blk_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pd_reset_seq #(
        .NUM_BLK(NB), .VALID_MASK(VMASK), .PD_CYCLES(PD), .SELFTEST_CYCLES(ST)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .blk_rst_n(blk_rst_n)
    );

    // Reference model: 0 running, 1 falling, 2 down, 3 self-test
    int    m_ph  [NB];
    int    m_left[NB];
    bit    m_req [NB];
    logic [31:0] exp_rd;
    bit    rd_pend;
    string cur_tag = "R1";

    function automatic logic [31:0] m_word(int k);
        logic [31:0] w = 32'h0;
        if (k < NB && VMASK[k]) begin
            if (m_req[k])     w = w | 32'h0000_0001;
            if (m_ph[k] == 2) w = w | 32'h0800_0000;
            if (m_ph[k] == 0) w = w | 32'h2000_0000;
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NB; k++) begin
                m_ph[k] = 2; m_left[k] = 0; m_req[k] = 1'b1;
            end
            rd_pend = 1'b0;
        end else begin
            rd_pend = bus_valid && !bus_write;
            if (rd_pend) exp_rd = m_word(int'(bus_addr >> 2));
            for (int k = 0; k < NB; k++) begin
                if (m_ph[k] == 0) begin
                    if (m_req[k]) begin m_ph[k] = 1; m_left[k] = PD; end
                end else if (m_ph[k] == 1) begin
                    m_left[k]--; if (m_left[k] == 0) m_ph[k] = 2;
                end else if (m_ph[k] == 2) begin
                    if (!m_req[k]) begin m_ph[k] = 3; m_left[k] = ST; end
                end else begin
                    m_left[k]--; if (m_left[k] == 0) m_ph[k] = 0;
                end
            end
            if (bus_valid && bus_write && VMASK[int'(bus_addr >> 2)])
                m_req[int'(bus_addr >> 2)] = bus_wdata[0];
        end
    end

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison of reset lines and of every read
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [NB-1:0] exp_n;
            string tg;
            tg = "R10";
            for (int k = 0; k < NB; k++) begin
                exp_n[k] = VMASK[k] && (m_ph[k] == 0 || m_ph[k] == 3);
                if (exp_n[k] !== blk_rst_n[k] && tg == "R10")
                    tg = !VMASK[k] ? "R9" : (m_ph[k] == 1 || m_ph[k] == 2) ? "R4" : "R5";
            end
            check(exp_n === blk_rst_n, tg, "reset lines", 32'(blk_rst_n), 32'(exp_n));
            if (rd_pend) check(bus_rdata === exp_rd, cur_tag, "read vs model", bus_rdata, exp_rd);
        end
    end

    task automatic wr(int idx, logic [31:0] d, logic [1:0] lo = 2'b00);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr  = AW'(idx * 4) | AW'(lo); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_exp(int idx, logic [31:0] exp, string tag, logic [1:0] lo = 2'b00);
        @(negedge clk);
        cur_tag   = tag;
        bus_valid = 1'b1; bus_write = 1'b0;
        bus_addr  = AW'(idx * 4) | AW'(lo);
        @(negedge clk);
        bus_valid = 1'b0;
        #1;
        check(bus_rdata === exp, tag, $sformatf("word %0d", idx), bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R3 reset state
        #1 check(blk_rst_n === '0, "R3", "lines after reset", 32'(blk_rst_n), 32'h0);
        rd_exp(0, 32'h0800_0001, "R3");
        rd_exp(12, 32'h0800_0001, "R3");

        // R5 release through self-test, R2 readback of request
        wr(0, 32'h0);
        rd_exp(0, 32'h0000_0000, "R2");
        check(blk_rst_n[0] === 1'b1, "R5", "line during self-test", 32'(blk_rst_n[0]), 32'h1);
        idle(ST + 4);
        rd_exp(0, 32'h2000_0000, "R5");

        // R8 stray bits ignored
        wr(0, 32'hFFFF_FFFE);
        rd_exp(0, 32'h2000_0000, "R8");

        // R4 power down, R1 low address bits ignored
        wr(0, 32'h0000_0001, 2'b11);
        idle(1);
        rd_exp(0, 32'h0000_0001, "R4");
        check(blk_rst_n[0] === 1'b0, "R4", "line while falling", 32'(blk_rst_n[0]), 32'h0);
        idle(PD + 2);
        rd_exp(0, 32'h0800_0001, "R4", 2'b10);
        rd_exp(0, 32'h0800_0001, "R1", 2'b01);

        // R7 request during self-test
        wr(1, 32'h0);
        idle(20);
        wr(1, 32'h1);
        idle(ST / 2);
        check(blk_rst_n[1] === 1'b1, "R7", "self-test not aborted", 32'(blk_rst_n[1]), 32'h1);
        rd_exp(1, 32'h0000_0001, "R7");
        idle(ST / 2 + PD + 10);
        rd_exp(1, 32'h0800_0001, "R7");

        // R7 release during falling phase
        wr(0, 32'h0);
        idle(ST + 4);
        wr(0, 32'h1);
        wr(0, 32'h0);
        check(blk_rst_n[0] === 1'b0, "R7", "fall not aborted", 32'(blk_rst_n[0]), 32'h0);
        idle(PD + ST + 10);
        rd_exp(0, 32'h2000_0000, "R7");

        // R9 invalid indices
        rd_exp(13, 32'h0, "R9");
        wr(13, 32'h0);
        wr(31, 32'h0);
        idle(ST + 10);
        rd_exp(13, 32'h0, "R9");
        rd_exp(31, 32'h0, "R9");
        check(blk_rst_n[31:13] === '0, "R9", "invalid lines", 32'(blk_rst_n[31:13]), 32'h0);

        // R10 independent blocks
        wr(2, 32'h0);
        idle(50);
        wr(3, 32'h0);
        idle(ST - 20);
        rd_exp(2, 32'h2000_0000, "R10");
        rd_exp(3, 32'h0000_0000, "R10");
        idle(40);

        // R6 exclusivity across all valid blocks
        for (int k = 0; k < 13; k++) begin
            rd_exp(k, m_word(k), "R6");
            check(!(bus_rdata[27] && bus_rdata[29]), "R6", "bits 27/29 together", bus_rdata, 32'h0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule